// File: doc/BRIEF.md
# Multiplier-Free Bit-Serial FIR Filter

This block is a fixed-coefficient FIR filter that uses no multipliers. Each accepted sample enters a tap delay line. The block then walks through the bit positions of the stored samples, starting at the least significant bit. On each step it takes the bit of that weight from every tap and uses those bits to address small tables. Each table holds every possible sum of a group of coefficients. The table outputs are added together, shifted to the weight of the current bit, and folded into a wide accumulator. The most significant bit carries negative weight in two's complement, so its partial sum is subtracted.

The coefficients are fixed when the design is elaborated. They are passed as one flat parameter vector, and tap index 0 is the newest sample. The taps are split into groups of four, and each group gets its own 16-entry table. After a sample is accepted the block reports busy for one clock per input bit. It then pulses a result strobe, and the full-precision sum appears on the output. Samples offered while the block is busy are ignored.

Top module: `da_fir_filter`

## Requirements
- R1: After reset, busy and out_valid are low, out_data is zero, and every tap of the delay line holds zero.
- R2: Each result equals the exact sum over k of coef[k] times tap[k]. tap[0] is the sample accepted last and tap[k] is the one accepted k acceptances earlier. Taps that have never been written count as zero.
- R3: Samples are 8-bit two's complement, with bit 7 weighted -128, so the value -128 is handled exactly.
- R4: A sample is accepted on a rising edge where in_valid is high and busy is low. Exactly 8 rising edges later, out_valid is high for exactly one cycle.
- R5: busy is high from the edge after an acceptance until the result is presented. in_valid raised while busy is high does not alter the delay line or any result.
- R6: out_data is DW+CW+log2(NTAPS) bits wide (21 by default) and never wraps, even for samples that drive the sum to its extreme.
- R7: out_data holds its last result, unchanged, until the next result is presented.
- R8: Coefficient k is the signed CW-bit field at bits [k*CW +: CW] of the COEFS parameter and weights the sample k positions back in the delay line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered this cycle |
| in_data | input | DW (8) | Two's complement input sample |
| busy | output | 1 | Accumulation in progress; new samples are ignored |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | OUT_W (21) | Signed full-precision filter result |

## Verification
A train of impulses, each followed by zeros, reads out every coefficient in turn. This shows both the table contents and the tap ordering. Long runs of constant -128 and +127 stress the negative weight of the top bit and the carries between groups. A pseudo-random stream mixes the signs of all groups in every result. Sample sequences whose signs match the coefficients push the sum to its positive and negative extremes to show the accumulator does not wrap. Junk strobes injected while busy must leave both the current and later results unchanged.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // Fixed width of the flat coefficient parameter (upper bits unused).
    localparam int COEF_VEC_BITS = 2048;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic clear;   // restart the accumulator for a new sample
        logic step;    // fold one bit position into the sum
        logic msb;     // current bit carries negative weight
    } acc_ctrl_t;

    // Signed value of coefficient idx, cw bits wide, from the flat vector.
    function automatic int coef_value(logic [COEF_VEC_BITS-1:0] flat, int idx, int cw);
        int v;
        v = 0;
        for (int b = 0; b < cw; b++) begin
            if (flat[idx*cw + b]) v = v + (1 << b);
        end
        if (flat[idx*cw + cw - 1]) v = v - (1 << cw);
        return v;
    endfunction

    // Default coefficient set: a deterministic spread of signed values.
    function automatic logic [COEF_VEC_BITS-1:0] spread_coefs(int ntaps, int cw);
        logic [COEF_VEC_BITS-1:0] v;
        int c;
        v = '0;
        for (int k = 0; k < ntaps; k++) begin
            c = ((k * 29 + 7) % (1 << (cw - 1))) - (1 << (cw - 2));
            for (int b = 0; b < cw; b++) begin
                if (k*cw + b < COEF_VEC_BITS) v[k*cw + b] = c[b];
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/da_tapline.sv
module da_tapline #(
    parameter int NTAPS = 32,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift,
    input  logic [DW-1:0]              din,
    output logic [NTAPS-1:0][DW-1:0]   taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps[0] <= '0;
        end else if (shift) begin
            taps[0] <= din;
        end
    end

    for (genvar k = 1; k < NTAPS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                taps[k] <= '0;
            end else if (shift) begin
                taps[k] <= taps[k-1];
            end
        end
    end

endmodule

// File: rtl/da_group_lut.sv
module da_group_lut
    import da_fir_pkg::*;
#(
    parameter int GRP  = 4,
    parameter int CW   = 8,
    parameter int GIDX = 0,
    parameter logic [COEF_VEC_BITS-1:0] COEFS = '0,
    parameter int GW   = CW + $clog2(GRP)
) (
    input  logic [GRP-1:0]        addr,
    output logic signed [GW-1:0]  val
);

    localparam int NENT = 1 << GRP;

    // Sum of the group's coefficients selected by the set bits of e.
    function automatic int entry_sum(int e);
        int s;
        s = 0;
        for (int i = 0; i < GRP; i++) begin
            if (((e >> i) & 1) == 1) s = s + coef_value(COEFS, GIDX*GRP + i, CW);
        end
        return s;
    endfunction

    logic signed [GW-1:0] tbl [NENT];

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        localparam int SUM = entry_sum(e);
        assign tbl[e] = GW'(SUM);
    end

    assign val = tbl[addr];

endmodule

// File: rtl/da_shift_acc.sv
module da_shift_acc
    import da_fir_pkg::*;
#(
    parameter int PW    = 13,
    parameter int OUT_W = 21,
    parameter int CNTW  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  acc_ctrl_t                ctrl,
    input  logic [CNTW-1:0]          bit_idx,
    input  logic signed [PW-1:0]     partial,
    output logic signed [OUT_W-1:0]  acc_next
);

    logic signed [OUT_W-1:0] acc;
    logic signed [OUT_W-1:0] term;
    logic        [OUT_W:0]   wide;

    always_comb begin
        term = OUT_W'(partial) <<< bit_idx;
        if (ctrl.msb) begin
            wide = {acc[OUT_W-1], acc} - {term[OUT_W-1], term};
        end else begin
            wide = {acc[OUT_W-1], acc} + {term[OUT_W-1], term};
        end
        acc_next = wide[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) begin
            acc <= '0;
        end else if (ctrl.step) begin
            acc <= acc_next;
        end
    end

    // R6: the extended sum never leaves the signed range of the output
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl.step |-> (wide[OUT_W] == wide[OUT_W-1]));

endmodule

// File: rtl/da_fir_filter.sv
module da_fir_filter
    import da_fir_pkg::*;
#(
    parameter int NTAPS = 32,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int GRP   = 4,
    parameter logic [COEF_VEC_BITS-1:0] COEFS = spread_coefs(NTAPS, CW),
    parameter int OUT_W = DW + CW + $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [DW-1:0]            in_data,
    output logic                     busy,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);

    localparam int NGRP = NTAPS / GRP;
    localparam int GW   = CW + $clog2(GRP);
    localparam int PW   = CW + $clog2(NTAPS);
    localparam int CNTW = $clog2(DW);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DW - 1);

    run_state_e           state;
    logic [CNTW-1:0]      bit_idx;
    logic                 accept;
    acc_ctrl_t            ctrl;

    logic [NTAPS-1:0][DW-1:0] taps;
    logic [NTAPS-1:0]         tap_bits;
    logic signed [GW-1:0]     grp_val [NGRP];
    logic signed [PW-1:0]     partial;
    logic signed [OUT_W-1:0]  acc_next;

    assign busy   = (state == ST_RUN);
    assign accept = in_valid && !busy;

    assign ctrl.clear = accept;
    assign ctrl.step  = busy;
    assign ctrl.msb   = (bit_idx == LAST_BIT);

    da_tapline #(.NTAPS(NTAPS), .DW(DW)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .shift (accept),
        .din   (in_data),
        .taps  (taps)
    );

    always_comb begin
        for (int k = 0; k < NTAPS; k++) begin
            tap_bits[k] = taps[k][bit_idx];
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        da_group_lut #(
            .GRP   (GRP),
            .CW    (CW),
            .GIDX  (g),
            .COEFS (COEFS),
            .GW    (GW)
        ) u_lut (
            .addr (tap_bits[g*GRP +: GRP]),
            .val  (grp_val[g])
        );
    end

    always_comb begin
        partial = '0;
        for (int g = 0; g < NGRP; g++) begin
            partial = partial + PW'(grp_val[g]);
        end
    end

    da_shift_acc #(.PW(PW), .OUT_W(OUT_W), .CNTW(CNTW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .bit_idx  (bit_idx),
        .partial  (partial),
        .acc_next (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_idx   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (accept) begin
                state   <= ST_RUN;
                bit_idx <= '0;
            end else if (busy) begin
                if (bit_idx == LAST_BIT) begin
                    state     <= ST_IDLE;
                    out_valid <= 1'b1;
                    out_data  <= acc_next;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    // R4: the result strobe lasts a single cycle
    assert_pulse_once_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4: a result appears only as a busy period ends
    assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(busy) && !busy));

    // R5: strobes offered while busy leave the delay line untouched
    assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && in_valid) |=> $stable(taps));

    // R7: between results the output value does not move
    assert_hold_result_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/sim_da_fir_filter.sv
module sim_da_fir_filter;
    import da_fir_pkg::*;

    localparam int NT = 32;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int OW = DW + CW + $clog2(NT);

    function automatic int bench_coef(int k);
        if (k == 5) return -128;
        if (k == 9) return 127;
        return ((k * 53 + 19) % 255) - 127;
    endfunction

    function automatic logic [COEF_VEC_BITS-1:0] bench_flat();
        logic [COEF_VEC_BITS-1:0] v;
        int c;
        v = '0;
        for (int k = 0; k < NT; k++) begin
            c = bench_coef(k);
            for (int b = 0; b < CW; b++) v[k*CW + b] = c[b];
        end
        return v;
    endfunction

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic busy, out_valid;
    logic signed [OW-1:0] out_data;

    int vectors = 0;
    int fails = 0;
    longint hist [NT];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    da_fir_filter #(.NTAPS(NT), .DW(DW), .CW(CW), .GRP(4), .COEFS(bench_flat())) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .busy(busy), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(string req, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model();
        longint s = 0;
        for (int k = 0; k < NT; k++) s += longint'(bench_coef(k)) * hist[k];
        return s;
    endfunction

    // Offer one sample, optionally strobe junk while busy, and check the result.
    task automatic send(logic signed [DW-1:0] x, bit junk, bit timing, string req);
        int n;
        while (busy) @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'(x);
        n = 0;
        if (timing) chk("R5 busy after accept", longint'(busy), 1);
        if (junk) begin
            in_valid = 1'b1;
            in_data  = 8'h5A;
            repeat (4) begin @(negedge clk); n++; end
            in_valid = 1'b0;
        end
        while (!out_valid && n < 30) begin @(negedge clk); n++; end
        if (timing) chk("R4 latency", longint'(n), 8);
        chk(req, longint'(out_data), model());
        @(negedge clk);
        if (timing) begin
            chk("R4 single pulse", longint'(out_valid), 0);
            chk("R5 busy clear after result", longint'(busy), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        longint held;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", longint'(busy), 0);
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_data", longint'(out_data), 0);

        // R1/R8: an impulse into cleared taps reads out coef[k] after k zeros
        send(8'sd1, 1'b0, 1'b1, "R1 cleared taps + R8 coef0");
        for (int k = 1; k < NT; k++) send(8'sd0, 1'b0, 1'b0, "R8 impulse coefficient order");
        send(8'sd0, 1'b0, 1'b1, "R8 impulse flushed");

        // R3: runs of the most negative and most positive sample values
        for (int i = 0; i < NT + 2; i++) send(8'h80, 1'b0, 1'b0, "R3 run of -128");
        for (int i = 0; i < NT + 2; i++) send(8'h7F, 1'b0, 1'b0, "R3 run of +127");

        // R6: sign-matched samples drive the sum to its positive extreme
        for (int k = NT-1; k >= 0; k--)
            send((bench_coef(k) < 0) ? 8'h80 : 8'h7F, 1'b0, 1'b0, "R6 positive extreme");
        // R6: anti-matched samples drive it to its negative extreme
        for (int k = NT-1; k >= 0; k--)
            send((bench_coef(k) < 0) ? 8'h7F : 8'h80, 1'b0, 1'b0, "R6 negative extreme");

        // R2/R3: pseudo-random two's complement stream
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr[7:0], 1'b0, (i % 50) == 0, "R2 random stream");
        end

        // R5: junk strobes during busy must not disturb this or later results
        send(8'sd37, 1'b1, 1'b1, "R5 junk during busy");
        send(-8'sd90, 1'b1, 1'b0, "R5 junk during busy");
        send(8'sd5, 1'b0, 1'b1, "R5 later result unaffected");

        // R7: output holds while idle
        held = longint'(out_data);
        repeat (6) @(negedge clk);
        chk("R7 hold while idle", longint'(out_data), held);
        chk("R7 no spurious strobe", longint'(out_valid), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule